// File: doc/BRIEF.md
# Timer Interrupt Router

This block sits behind the comparators of an event timer and turns each channel's fire strobe into an interrupt. For each channel it works out a validated line route and the delivery mode, then produces one of four results: nothing, a one-cycle pulse on a line, a held level on a line, or a message write request. The message request carries a 32-bit address and a 32-bit data word, both taken from a 64-bit per-channel message register.

Each channel has a status bit with write-one-to-clear behaviour. The bit is only used for level-triggered line interrupts, and it blocks repeated interrupts while it stays set. The bit also drops by itself when a configuration change would leave its level hanging.

The set of routes a channel may use comes from the number of interrupt lines present. Any other route is replaced by zero, which means unrouted. Each interrupt line output is the OR of every channel that drives that line.

Top module: `tmr_irq_router`

## Requirements
- R1: A fire strobe on a channel whose interrupt-enable input is 0 produces no pulse, no level, no message request and no status change.
- R2: While a channel's status bit is 1, a further fire strobe on that channel produces no pulse and no message request, and its line level stays as it was.
- R3: Message mode is active only when the channel's message-capable parameter bit (MSG_CAP bit c) and its message-enable input are both 1. A fire strobe in message mode raises msgReq[c] for exactly the one cycle after the fire edge. In that cycle msgAddr for the channel equals bits 63:32 of its message register and msgData equals bits 31:0. The status bit stays 0.
- R4: While message mode is active, the channel's routeIdx reads 0 and the channel drives no line.
- R5: A fire strobe on a channel whose effective route is 0 produces no line activity and no status change.
- R6: With cfgLevel=0 (edge), a fire strobe raises linePulse[route] for exactly the one cycle after the fire edge and leaves the status bit 0.
- R7: With cfgLevel=1 (level), a fire strobe sets stsBits[c] and holds lineLevel[route] at 1 from the cycle after the fire edge.
- R8: A status write with stsWrEn=1 and data bit c = 1 clears stsBits[c] and releases the channel's level one cycle later. The same write on a bit that is already 0 changes nothing.
- R9: A programmed route that is nonzero and absent from the allowed-route mask is forced to 0, and routeIdx shows the forced value one cycle after the configuration is applied.
- R10: A set status bit is cleared, and its level released, one cycle after any of these: interrupt-enable goes to 0, message mode becomes active, edge mode is selected, or the validated route changes.
- R11: The allowed-route mask depends on NUM_LINES. It allows routes 24 to 31 for 32 or more lines, the top four lines for 20 to 31 lines, and no route below 20 lines. With the default of 24 lines, only routes 20 to 23 are allowed.
- R12: Each lineLevel bit is the OR of all channels holding a level on that route, so the line stays high until the last such channel is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fireStb | input | NUM_CH | Comparator fire strobe per channel |
| cfgIntEn | input | NUM_CH | Interrupt enable per channel |
| cfgLevel | input | NUM_CH | Trigger type: 0 edge, 1 level |
| cfgMsgEn | input | NUM_CH | Message delivery enable per channel |
| cfgRoute | input | NUM_CH*5 | Programmed line route per channel |
| cfgMsgReg | input | NUM_CH*64 | Message register per channel (address high, data low) |
| stsWrEn | input | 1 | Status write strobe |
| stsWrData | input | NUM_CH | Status write data, 1 clears a set bit |
| routeIdx | output | NUM_CH*5 | Validated route per channel |
| linePulse | output | NUM_LINES | One-cycle edge pulses per line |
| lineLevel | output | NUM_LINES | Held level per line |
| stsBits | output | NUM_CH | Status bit per channel |
| msgReq | output | NUM_CH | One-cycle message request per channel |
| msgAddr | output | NUM_CH*32 | Message address per channel |
| msgData | output | NUM_CH*32 | Message data per channel |

## Verification
A status bit stuck high shows up at the ports in two ways. The line level stays asserted after a clear write or a configuration change. Later fire strobes on that channel also go silent, both within one cycle. A wrong registered route shows up in the cycle after the configuration is applied, either on routeIdx or as a level on the wrong line. A wrong delivery decision shows up on the pulse, level or message outputs in the single cycle after the fire edge, where the bench samples them.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int ROUTE_W = 5;

  // per-channel strobes from control to datapath
  typedef struct packed {
    logic setSts;
    logic dropSts;
    logic fireEdge;
    logic fireMsg;
  } chStb_t;

  // routes a channel may select, derived from the number of lines
  function automatic logic [31:0] allowedRoutes(input int lines);
    if (lines >= 32) return 32'hFF00_0000;
    else if (lines >= 20) return 32'h0000_000F << (lines - 4);
    else return 32'h0;
  endfunction
endpackage

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
  import tmr_irq_pkg::*;
#(
  parameter int          NUM_CH    = 3,
  parameter int          NUM_LINES = 24,
  parameter int unsigned MSG_CAP   = 32'h3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_CH-1:0]           fireStb,
  input  logic [NUM_CH-1:0]           cfgIntEn,
  input  logic [NUM_CH-1:0]           cfgLevel,
  input  logic [NUM_CH-1:0]           cfgMsgEn,
  input  logic [NUM_CH*ROUTE_W-1:0]   cfgRoute,
  input  logic [NUM_CH-1:0]           stsQ,
  input  logic [NUM_CH*ROUTE_W-1:0]   effRouteQ,
  output chStb_t [NUM_CH-1:0]         stb,
  output logic [NUM_CH*ROUTE_W-1:0]   routeNext
);
  localparam logic [31:0] ALLOWED = allowedRoutes(NUM_LINES);

  for (genvar c = 0; c < NUM_CH; c++) begin : gCh
    logic               msgMode;
    logic [ROUTE_W-1:0] progRoute;
    logic [ROUTE_W-1:0] valRoute;
    logic               live;

    assign msgMode   = MSG_CAP[c] & cfgMsgEn[c];
    assign progRoute = cfgRoute[c*ROUTE_W +: ROUTE_W];
    assign valRoute  = (msgMode || !ALLOWED[progRoute]) ? '0 : progRoute;
    assign routeNext[c*ROUTE_W +: ROUTE_W] = valRoute;

    assign live = fireStb[c] & cfgIntEn[c] & ~stsQ[c];

    assign stb[c].fireMsg  = live & msgMode;
    assign stb[c].fireEdge = live & ~msgMode & (valRoute != '0) & ~cfgLevel[c];
    assign stb[c].setSts   = live & ~msgMode & (valRoute != '0) & cfgLevel[c];
    assign stb[c].dropSts  = stsQ[c] & (~cfgIntEn[c] | msgMode | ~cfgLevel[c] |
                             (valRoute != effRouteQ[c*ROUTE_W +: ROUTE_W]));

    AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0({stb[c].setSts, stb[c].fireEdge, stb[c].fireMsg})); // R6
    AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rstN)
      stb[c].setSts |=> stsQ[c]); // R7
    AST_DROP_TAKES: assert property (@(posedge clk) disable iff (!rstN)
      stb[c].dropSts |=> !stsQ[c]); // R10
  end
endmodule

// File: rtl/tmr_irq_dp.sv
module tmr_irq_dp
  import tmr_irq_pkg::*;
#(
  parameter int NUM_CH    = 3,
  parameter int NUM_LINES = 24
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  chStb_t [NUM_CH-1:0]       stb,
  input  logic [NUM_CH*ROUTE_W-1:0] routeNext,
  input  logic                      stsWrEn,
  input  logic [NUM_CH-1:0]         stsWrData,
  input  logic [NUM_CH*64-1:0]      cfgMsgReg,
  output logic [NUM_CH-1:0]         stsQ,
  output logic [NUM_CH*ROUTE_W-1:0] effRouteQ,
  output logic [NUM_LINES-1:0]      linePulse,
  output logic [NUM_LINES-1:0]      lineLevel,
  output logic [NUM_CH-1:0]         msgReq,
  output logic [NUM_CH*32-1:0]      msgAddr,
  output logic [NUM_CH*32-1:0]      msgData
);
  localparam logic [31:0] ALLOWED = allowedRoutes(NUM_LINES);

  logic [NUM_LINES-1:0] pulseNext;

  always_comb begin
    pulseNext = '0;
    lineLevel = '0;
    for (int l = 0; l < NUM_LINES; l++) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (stb[c].fireEdge && int'(routeNext[c*ROUTE_W +: ROUTE_W]) == l)
          pulseNext[l] = 1'b1;
        if (stsQ[c] && int'(effRouteQ[c*ROUTE_W +: ROUTE_W]) == l)
          lineLevel[l] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stsQ      <= '0;
      effRouteQ <= '0;
      linePulse <= '0;
      msgReq    <= '0;
      msgAddr   <= '0;
      msgData   <= '0;
    end else begin
      effRouteQ <= routeNext;
      linePulse <= pulseNext;
      for (int c = 0; c < NUM_CH; c++) begin
        if (stb[c].dropSts || (stsWrEn && stsWrData[c])) stsQ[c] <= 1'b0;
        if (stb[c].setSts) stsQ[c] <= 1'b1;
        msgReq[c] <= stb[c].fireMsg;
        if (stb[c].fireMsg) begin
          msgAddr[c*32 +: 32] <= cfgMsgReg[c*64+32 +: 32];
          msgData[c*32 +: 32] <= cfgMsgReg[c*64 +: 32];
        end
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : gChk
    AST_STS_ROUTED: assert property (@(posedge clk) disable iff (!rstN)
      stsQ[c] |-> effRouteQ[c*ROUTE_W +: ROUTE_W] != '0); // R7
    AST_MSG_UNROUTED: assert property (@(posedge clk) disable iff (!rstN)
      msgReq[c] |-> effRouteQ[c*ROUTE_W +: ROUTE_W] == '0); // R4
    AST_ROUTE_ALLOWED: assert property (@(posedge clk) disable iff (!rstN)
      effRouteQ[c*ROUTE_W +: ROUTE_W] != '0 |-> ALLOWED[effRouteQ[c*ROUTE_W +: ROUTE_W]]); // R9
    AST_W1C: assert property (@(posedge clk) disable iff (!rstN)
      (stsWrEn && stsWrData[c] && stsQ[c]) |=> !stsQ[c]); // R8
  end
endmodule

// File: rtl/tmr_irq_router.sv
module tmr_irq_router
  import tmr_irq_pkg::*;
#(
  parameter int          NUM_CH    = 3,
  parameter int          NUM_LINES = 24,
  parameter int unsigned MSG_CAP   = 32'h3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_CH-1:0]         fireStb,
  input  logic [NUM_CH-1:0]         cfgIntEn,
  input  logic [NUM_CH-1:0]         cfgLevel,
  input  logic [NUM_CH-1:0]         cfgMsgEn,
  input  logic [NUM_CH*5-1:0]       cfgRoute,
  input  logic [NUM_CH*64-1:0]      cfgMsgReg,
  input  logic                      stsWrEn,
  input  logic [NUM_CH-1:0]         stsWrData,
  output logic [NUM_CH*5-1:0]       routeIdx,
  output logic [NUM_LINES-1:0]      linePulse,
  output logic [NUM_LINES-1:0]      lineLevel,
  output logic [NUM_CH-1:0]         stsBits,
  output logic [NUM_CH-1:0]         msgReq,
  output logic [NUM_CH*32-1:0]      msgAddr,
  output logic [NUM_CH*32-1:0]      msgData
);
  chStb_t [NUM_CH-1:0]       stb;
  logic [NUM_CH*ROUTE_W-1:0] routeNext;
  logic [NUM_CH-1:0]         stsQ;
  logic [NUM_CH*ROUTE_W-1:0] effRouteQ;

  tmr_irq_ctrl #(.NUM_CH(NUM_CH), .NUM_LINES(NUM_LINES), .MSG_CAP(MSG_CAP)) uCtrl (
    .clk(clk), .rstN(rstN), .fireStb(fireStb), .cfgIntEn(cfgIntEn),
    .cfgLevel(cfgLevel), .cfgMsgEn(cfgMsgEn), .cfgRoute(cfgRoute),
    .stsQ(stsQ), .effRouteQ(effRouteQ), .stb(stb), .routeNext(routeNext)
  );

  tmr_irq_dp #(.NUM_CH(NUM_CH), .NUM_LINES(NUM_LINES)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .routeNext(routeNext),
    .stsWrEn(stsWrEn), .stsWrData(stsWrData), .cfgMsgReg(cfgMsgReg),
    .stsQ(stsQ), .effRouteQ(effRouteQ), .linePulse(linePulse),
    .lineLevel(lineLevel), .msgReq(msgReq), .msgAddr(msgAddr), .msgData(msgData)
  );

  assign routeIdx = effRouteQ;
  assign stsBits  = stsQ;
endmodule

// File: tb/tmr_irq_router_test.sv
module tmr_irq_router_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic [2:0]  fireStb, cfgIntEn, cfgLevel, cfgMsgEn, stsWrData;
  logic        stsWrEn;
  logic [4:0]  rt [3];
  logic [14:0] cfgRoute;
  logic [191:0] cfgMsgReg;
  logic [14:0] routeIdx;
  logic [23:0] linePulse, lineLevel;
  logic [2:0]  stsBits, msgReq;
  logic [95:0] msgAddr, msgData;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  assign cfgRoute = {rt[2], rt[1], rt[0]};

  tmr_irq_router uut (
    .clk(clk), .rstN(rstN), .fireStb(fireStb), .cfgIntEn(cfgIntEn),
    .cfgLevel(cfgLevel), .cfgMsgEn(cfgMsgEn), .cfgRoute(cfgRoute),
    .cfgMsgReg(cfgMsgReg), .stsWrEn(stsWrEn), .stsWrData(stsWrData),
    .routeIdx(routeIdx), .linePulse(linePulse), .lineLevel(lineLevel),
    .stsBits(stsBits), .msgReq(msgReq), .msgAddr(msgAddr), .msgData(msgData)
  );

  typedef struct packed {
    logic [1:0]  ch;
    logic        en, lvl, msg, fire;
    logic [4:0]  route;
    logic [2:0]  clr;
    logic [4:0]  expRoute;
    logic [23:0] expPulse;
    logic [23:0] expLevel;
    logic [2:0]  expSts;
    logic [2:0]  expMsg;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{2'd0,1'b0,1'b0,1'b0,1'b1,5'd20,3'd0,5'd20,24'h0,     24'h0,     3'd0,3'd0,4'd1 },  // R1 disabled
    '{2'd0,1'b1,1'b0,1'b0,1'b1,5'd20,3'd0,5'd20,24'h100000,24'h0,     3'd0,3'd0,4'd6 },  // R6 edge pulse
    '{2'd0,1'b1,1'b0,1'b0,1'b1,5'd0, 3'd0,5'd0, 24'h0,     24'h0,     3'd0,3'd0,4'd5 },  // R5 unrouted
    '{2'd0,1'b1,1'b0,1'b0,1'b1,5'd5, 3'd0,5'd0, 24'h0,     24'h0,     3'd0,3'd0,4'd9 },  // R9 forced to 0
    '{2'd0,1'b1,1'b1,1'b0,1'b1,5'd21,3'd0,5'd21,24'h0,     24'h200000,3'd1,3'd0,4'd7 },  // R7 level
    '{2'd0,1'b1,1'b1,1'b0,1'b1,5'd21,3'd0,5'd21,24'h0,     24'h200000,3'd1,3'd0,4'd2 },  // R2 already set
    '{2'd1,1'b1,1'b1,1'b0,1'b1,5'd21,3'd0,5'd21,24'h0,     24'h200000,3'd3,3'd0,4'd12},  // R12 shared line
    '{2'd1,1'b1,1'b1,1'b0,1'b0,5'd21,3'd1,5'd21,24'h0,     24'h200000,3'd2,3'd0,4'd8 },  // R8 clear ch0
    '{2'd1,1'b1,1'b1,1'b0,1'b0,5'd21,3'd1,5'd21,24'h0,     24'h200000,3'd2,3'd0,4'd8 },  // R8 clear already-clear bit
    '{2'd1,1'b1,1'b1,1'b0,1'b0,5'd22,3'd0,5'd22,24'h0,     24'h0,     3'd0,3'd0,4'd10},  // R10 route change
    '{2'd1,1'b1,1'b1,1'b0,1'b1,5'd22,3'd0,5'd22,24'h0,     24'h400000,3'd2,3'd0,4'd7 },  // R7
    '{2'd1,1'b1,1'b0,1'b0,1'b0,5'd22,3'd0,5'd22,24'h0,     24'h0,     3'd0,3'd0,4'd10},  // R10 edge selected
    '{2'd1,1'b1,1'b1,1'b0,1'b1,5'd22,3'd0,5'd22,24'h0,     24'h400000,3'd2,3'd0,4'd7 },  // R7
    '{2'd1,1'b0,1'b1,1'b0,1'b0,5'd22,3'd0,5'd22,24'h0,     24'h0,     3'd0,3'd0,4'd10},  // R10 disabled
    '{2'd0,1'b1,1'b0,1'b1,1'b1,5'd20,3'd0,5'd0, 24'h0,     24'h0,     3'd0,3'd1,4'd3 },  // R3 message
    '{2'd0,1'b1,1'b1,1'b1,1'b1,5'd20,3'd0,5'd0, 24'h0,     24'h0,     3'd0,3'd1,4'd4 },  // R4 message, no line
    '{2'd2,1'b1,1'b0,1'b1,1'b1,5'd23,3'd0,5'd23,24'h800000,24'h0,     3'd0,3'd0,4'd3 },  // R3 not capable
    '{2'd1,1'b1,1'b1,1'b0,1'b1,5'd22,3'd0,5'd22,24'h0,     24'h400000,3'd2,3'd0,4'd7 },  // R7
    '{2'd1,1'b1,1'b1,1'b1,1'b0,5'd22,3'd0,5'd0, 24'h0,     24'h0,     3'd0,3'd0,4'd10},  // R10 message on
    '{2'd2,1'b1,1'b1,1'b0,1'b1,5'd23,3'd0,5'd23,24'h0,     24'h800000,3'd4,3'd0,4'd7 },  // R7
    '{2'd0,1'b1,1'b1,1'b0,1'b1,5'd23,3'd0,5'd23,24'h0,     24'h800000,3'd5,3'd0,4'd12},  // R12
    '{2'd0,1'b1,1'b1,1'b0,1'b0,5'd23,3'd4,5'd23,24'h0,     24'h800000,3'd1,3'd0,4'd12},  // R12 one left
    '{2'd0,1'b1,1'b1,1'b0,1'b0,5'd23,3'd1,5'd23,24'h0,     24'h0,     3'd0,3'd0,4'd8 }   // R8 last cleared
  };

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; fireStb = '0; cfgIntEn = '0; cfgLevel = '0; cfgMsgEn = '0;
    stsWrEn = 1'b0; stsWrData = '0;
    for (int i = 0; i < 3; i++) rt[i] = '0;
    cfgMsgReg = {64'h0, 64'h0, 64'hFEE0_1234_0000_00A5};
    repeat (3) @(negedge clk);
    // reset state
    chk("RST", "stsBits", 64'(stsBits), 64'h0);
    chk("RST", "lineLevel", 64'(lineLevel), 64'h0);
    chk("RST", "linePulse", 64'(linePulse), 64'h0);
    chk("RST", "msgReq", 64'(msgReq), 64'h0);
    chk("RST", "routeIdx", 64'(routeIdx), 64'h0);
    rstN = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      vec_t x = VECS[v];
      string req = $sformatf("R%0d vec %0d", x.req, v);
      cfgIntEn[x.ch] = x.en; cfgLevel[x.ch] = x.lvl; cfgMsgEn[x.ch] = x.msg;
      rt[x.ch] = x.route; fireStb[x.ch] = x.fire;
      stsWrEn = (x.clr != 0); stsWrData = x.clr;
      @(negedge clk);
      chk(req, "routeIdx", 64'(routeIdx[x.ch*5 +: 5]), 64'(x.expRoute));
      chk(req, "linePulse", 64'(linePulse), 64'(x.expPulse));
      chk(req, "lineLevel", 64'(lineLevel), 64'(x.expLevel));
      chk(req, "stsBits", 64'(stsBits), 64'(x.expSts));
      chk(req, "msgReq", 64'(msgReq), 64'(x.expMsg));
      fireStb = '0; stsWrEn = 1'b0; stsWrData = '0;
    end

    // R11: route sweep on channel 2, only 20..23 allowed with 24 lines
    cfgIntEn[2] = 1'b0; cfgLevel[2] = 1'b0; cfgMsgEn[2] = 1'b0;
    for (int r = 0; r < 32; r++) begin
      rt[2] = 5'(r);
      @(negedge clk);
      chk("R11", $sformatf("routeIdx for route %0d", r), 64'(routeIdx[14:10]),
          (r >= 20 && r <= 23) ? 64'(r) : 64'h0);
    end

    // R3: message address and data, single-cycle request
    cfgIntEn[0] = 1'b1; cfgLevel[0] = 1'b0; cfgMsgEn[0] = 1'b1; rt[0] = 5'd20;
    fireStb[0] = 1'b1;
    @(negedge clk);
    fireStb = '0;
    chk("R3", "msgReq[0]", 64'(msgReq[0]), 64'h1);
    chk("R3", "msgAddr[0]", 64'(msgAddr[31:0]), 64'hFEE0_1234);
    chk("R3", "msgData[0]", 64'(msgData[31:0]), 64'h0000_00A5);
    chk("R3", "stsBits", 64'(stsBits), 64'h0);
    @(negedge clk);
    chk("R3", "msgReq after one cycle", 64'(msgReq), 64'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule